// File: doc/BRIEF.md
# Four-Rail Power Sequencer with Comparator-Paced Steps

This controller brings up four supply rails one after another in a fixed order and takes them down in the opposite order. It needs no external timing capacitors. Each step is paced by comparator flags that watch the gate drive voltages. A millisecond tick times two things: the settling window before start-up, and the hold-off between the last rail coming up and the release of the power-good output.

The block sees four under-voltage-good flags, an active-low enable and a shared open-drain system-reset line. That line is modelled as a sensed level and a pull-low request. If any under-voltage flag drops, all rails are cut at once. If the drop lasts past a short filter, the block also pulls the shared line low so that sequencers sharing the line shut down together. An outside low on the shared line forces everything off. Releasing the line while all inputs are good starts the ramp at once, without the settling window. Gate index 0 is rail A and index 3 is rail D.

Top module: `seq4_ctrl`

## Requirements
- R1: After reset, gate_on is 4'b0000, pwr_good is 0 and sysrst_pull is 0.
- R2: Start-up needs QUAL_MS ticks while all uv_ok bits are 1, en_n is 0 and sysrst_in is 1. If any of these drops, the tick count starts again from zero. After the tick that completes the count, gate_on reads 4'b0001 at the next cycle.
- R3: Rails come on in the order A, B, C, D (bit 0 up to bit 3). The next bit is set one cycle after near_full of the newest enabled gate is 1. near_full of any other gate has no effect.
- R4: Once near_full[3] is seen, pwr_good rises after RST_MS further ticks. pwr_good is 1 only while gate_on is 4'b1111.
- R5: When en_n goes to 1, pwr_good drops and the newest enabled gate is cleared in the next cycle. Each lower gate is cleared one cycle after gate_low of the gate just cleared is 1. gate_low of any other gate has no effect.
- R6: If any uv_ok bit is 0 at a clock edge, gate_on is 4'b0000 and pwr_good is 0 after that edge.
- R7: sysrst_pull rises only after uv_ok has been incomplete for more than FILT_CYC consecutive cycles. It falls one cycle after uv_ok is complete again.
- R8: A 0 on sysrst_in clears gate_on and pwr_good in the next cycle, whatever the other inputs are.
- R9: If sysrst_in rises while uv_ok is complete and en_n is 0, gate_on reads 4'b0001 in the next cycle without waiting for the settling window. This does not apply when the low was caused by this block's own sysrst_pull.
- R10: After an under-voltage fault clears, start-up again needs the full QUAL_MS settling window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| uv_ok | input | 4 | Per-rail under-voltage-good flags |
| en_n | input | 1 | Active-low enable |
| near_full | input | 4 | Per-gate flag: drive within about 1 V of full-on |
| gate_low | input | 4 | Per-gate flag: drive below about 0.6 V |
| sysrst_in | input | 1 | Sensed level of the shared system-reset line |
| gate_on | output | 4 | Per-rail gate-on request, bit 0 is rail A |
| pwr_good | output | 1 | High when the reset output is released |
| sysrst_pull | output | 1 | Request to pull the shared line low |

## Verification
On every cycle the assertions check four rules. Gates are always enabled as a contiguous run from rail A. Power-good never coexists with a partly enabled set. A low shared line or an under-voltage flag empties the gate set at the following edge. The pull request only follows an under-voltage condition. Only the bench scenarios can show the timing side: restart of the settling window, the exact tick counts, paced advance and the rejection of flags from the wrong gate, filter length, the skip on line release, and requalification after a fault.

// File: rtl/seq4_pkg.sv
package seq4_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UP,
        ST_HOLD,
        ST_RUN,
        ST_DOWN
    } seq_state_e;
endpackage

// File: rtl/seq4_uv_filter.sv
module seq4_uv_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_bad,
    output logic pull
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pull;
    } filt_t;

    filt_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!uv_bad) begin
            r_d.cnt  = '0;
            r_d.pull = 1'b0;
        end else begin
            if (r_q.cnt != CW'(FILT_CYC)) begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
            // fault has persisted beyond the filter window
            r_d.pull = (r_q.cnt == CW'(FILT_CYC));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pull = r_q.pull;
endmodule

// File: rtl/seq4_fsm.sv
module seq4_fsm
    import seq4_pkg::*;
#(
    parameter int NG      = 4,
    parameter int QUAL_MS = 10,
    parameter int RST_MS  = 160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          uv_bad,
    input  logic          en_ok,
    input  logic [NG-1:0] near_full,
    input  logic [NG-1:0] gate_low,
    input  logic          line_in,
    input  logic          own_pull,
    output logic [NG-1:0] gates,
    output logic          good
);
    localparam int IW   = (NG > 1) ? $clog2(NG) : 1;
    localparam int MAXC = (QUAL_MS > RST_MS) ? QUAL_MS : RST_MS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [IW-1:0] TOP = IW'(NG - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [IW-1:0] idx;
        logic [CW-1:0] cnt;
        logic [NG-1:0] gates;
        logic          good;
        logic          prev_line;
        logic          own;
    } fsm_t;

    fsm_t r_q, r_d;
    logic          rise;
    logic [IW-1:0] idx_inc, idx_dec;

    assign idx_inc = r_q.idx + 1'b1;
    assign idx_dec = r_q.idx - 1'b1;
    // rising edge of the shared line not caused by this block's own pull
    assign rise    = line_in && !r_q.prev_line && !r_q.own;

    always_comb begin
        r_d           = r_q;
        r_d.prev_line = line_in;
        r_d.own       = own_pull ? 1'b1 : (line_in ? 1'b0 : r_q.own);

        if (!line_in || uv_bad) begin
            r_d.st    = ST_IDLE;
            r_d.gates = '0;
            r_d.good  = 1'b0;
            r_d.cnt   = '0;
            r_d.idx   = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (!en_ok) begin
                        r_d.cnt = '0;
                    end else if (rise || (tick && r_q.cnt == CW'(QUAL_MS - 1))) begin
                        r_d.st    = ST_UP;
                        r_d.idx   = '0;
                        r_d.cnt   = '0;
                        r_d.gates = NG'(1);
                    end else if (tick) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_UP: begin
                    if (!en_ok) begin
                        r_d.st             = ST_DOWN;
                        r_d.gates[r_q.idx] = 1'b0;
                    end else if (near_full[r_q.idx]) begin
                        if (r_q.idx == TOP) begin
                            r_d.st  = ST_HOLD;
                            r_d.cnt = '0;
                        end else begin
                            r_d.idx            = idx_inc;
                            r_d.gates[idx_inc] = 1'b1;
                        end
                    end
                end
                ST_HOLD, ST_RUN: begin
                    if (!en_ok) begin
                        r_d.st         = ST_DOWN;
                        r_d.idx        = TOP;
                        r_d.gates[TOP] = 1'b0;
                        r_d.good       = 1'b0;
                    end else if (r_q.st == ST_HOLD && tick) begin
                        if (r_q.cnt == CW'(RST_MS - 1)) begin
                            r_d.st   = ST_RUN;
                            r_d.good = 1'b1;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_DOWN: begin
                    if (gate_low[r_q.idx]) begin
                        if (r_q.idx == '0) begin
                            r_d.st  = ST_IDLE;
                            r_d.cnt = '0;
                        end else begin
                            r_d.idx            = idx_dec;
                            r_d.gates[idx_dec] = 1'b0;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= ST_IDLE;
            r_q.prev_line <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign gates = r_q.gates;
    assign good  = r_q.good;
endmodule

// File: rtl/seq4_ctrl.sv
module seq4_ctrl #(
    parameter int NG       = 4,
    parameter int QUAL_MS  = 10,
    parameter int RST_MS   = 160,
    parameter int FILT_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_ms,
    input  logic [NG-1:0] uv_ok,
    input  logic          en_n,
    input  logic [NG-1:0] near_full,
    input  logic [NG-1:0] gate_low,
    input  logic          sysrst_in,
    output logic [NG-1:0] gate_on,
    output logic          pwr_good,
    output logic          sysrst_pull
);
    logic uv_bad;
    logic pull_w;

    assign uv_bad = ~&uv_ok;

    seq4_uv_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .uv_bad (uv_bad),
        .pull   (pull_w)
    );

    seq4_fsm #(.NG(NG), .QUAL_MS(QUAL_MS), .RST_MS(RST_MS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_ms),
        .uv_bad    (uv_bad),
        .en_ok     (!en_n),
        .near_full (near_full),
        .gate_low  (gate_low),
        .line_in   (sysrst_in),
        .own_pull  (pull_w),
        .gates     (gate_on),
        .good      (pwr_good)
    );

    assign sysrst_pull = pull_w;
endmodule

// File: rtl/seq4_ctrl_chk.sv
module seq4_ctrl_chk #(
    parameter int NG = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NG-1:0] uv_ok,
    input logic          sysrst_in,
    input logic [NG-1:0] gate_on,
    input logic          pwr_good,
    input logic          sysrst_pull
);
    AST_GATES_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_on + 1'b1) & gate_on) == '0); // R3
    AST_GOOD_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> (&gate_on)); // R4
    AST_UV_CUTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(&uv_ok) |=> (gate_on == '0 && !pwr_good)); // R6
    AST_PULL_FROM_UV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysrst_pull) |-> $past(!(&uv_ok))); // R7
    AST_LINE_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sysrst_in |=> (gate_on == '0 && !pwr_good)); // R8
endmodule

bind seq4_ctrl seq4_ctrl_chk #(.NG(NG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .uv_ok       (uv_ok),
    .sysrst_in   (sysrst_in),
    .gate_on     (gate_on),
    .pwr_good    (pwr_good),
    .sysrst_pull (sysrst_pull)
);

// File: tb/seq4_ctrl_tb.sv
module seq4_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL = 3;
    localparam int RSTD = 4;
    localparam int FILT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] uv_ok = 4'hF;
    logic       en_n = 1'b1;
    logic [3:0] nf = 4'h0;
    logic [3:0] gl = 4'h0;
    logic       ext_line = 1'b1;
    logic       line;
    logic [3:0] gate_on;
    logic       pwr_good;
    logic       sysrst_pull;

    int n_chk = 0;
    int n_err = 0;

    assign line = ext_line & ~sysrst_pull;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seq4_ctrl #(.NG(4), .QUAL_MS(QUAL), .RST_MS(RSTD), .FILT_CYC(FILT)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick), .uv_ok(uv_ok), .en_n(en_n),
        .near_full(nf), .gate_low(gl), .sysrst_in(line),
        .gate_on(gate_on), .pwr_good(pwr_good), .sysrst_pull(sysrst_pull)
    );

    function automatic logic [3:0] mask(int k);
        return 4'((1 << k) - 1);
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick1();
        tick = 1'b1;
        step(1);
        tick = 1'b0;
    endtask

    // qualify, then raise rails up to stop (gates = mask(stop+1)); stop==3 runs to power-good
    task automatic bring_up(int stop);
        en_n = 1'b0;
        for (int t = 0; t < QUAL - 1; t++) tick1();
        chk("R2 wait", gate_on, 4'h0);
        tick1();
        chk("R2 start", gate_on, 4'h1);
        for (int i = 0; i < stop; i++) begin
            nf = 4'(1 << (i + 1));
            step(1);
            chk("R3 wrong near_full", gate_on, mask(i + 1));
            nf = 4'(1 << i);
            step(1);
            nf = 4'h0;
            chk("R3 order", gate_on, mask(i + 2));
        end
        if (stop == 3) begin
            nf = 4'h8;
            step(1);
            nf = 4'h0;
            for (int t = 0; t < RSTD - 1; t++) tick1();
            chk("R4 hold", {3'b0, pwr_good}, 4'h0);
            tick1();
            chk("R4 good", {3'b0, pwr_good}, 4'h1);
            chk("R4 all on", gate_on, 4'hF);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        step(2);
        chk("R1 gates", gate_on, 4'h0);
        chk("R1 good", {3'b0, pwr_good}, 4'h0);
        chk("R1 pull", {3'b0, sysrst_pull}, 4'h0);
        rst_n = 1'b1;
        step(1);

        // R2: disabled ticks do nothing; a drop restarts the count
        for (int t = 0; t < QUAL + 2; t++) tick1();
        chk("R2 disabled", gate_on, 4'h0);
        en_n = 1'b0;
        for (int t = 0; t < QUAL - 1; t++) tick1();
        uv_ok = 4'b1011;
        step(1);
        uv_ok = 4'hF;
        for (int t = 0; t < QUAL - 1; t++) tick1();
        chk("R2 restart", gate_on, 4'h0);
        tick1();
        chk("R2 start", gate_on, 4'h1);
        ext_line = 1'b0;
        step(1);
        chk("R8 off", gate_on, 4'h0);
        en_n = 1'b1;
        ext_line = 1'b1;
        step(2);

        // R5 sweep: shut down from every ramp stage
        for (int stop = 0; stop < 4; stop++) begin
            bring_up(stop);
            en_n = 1'b1;
            step(1);
            chk("R5 top off", gate_on, mask(stop));
            chk("R5 good low", {3'b0, pwr_good}, 4'h0);
            for (int j = stop; j >= 0; j--) begin
                if (j > 0) begin
                    gl = 4'(1 << (j - 1));
                    step(1);
                    chk("R5 wrong gate_low", gate_on, mask(j));
                end
                gl = 4'(1 << j);
                step(1);
                gl = 4'h0;
                chk("R5 shed", gate_on, mask(j > 0 ? j - 1 : 0));
            end
            step(2);
            chk("R5 idle", gate_on, 4'h0);
        end

        // R6/R7: fault in run, filter, R10 requalification
        bring_up(3);
        uv_ok = 4'b1101;
        step(1);
        chk("R6 cut", gate_on, 4'h0);
        chk("R6 good", {3'b0, pwr_good}, 4'h0);
        chk("R7 filtered", {3'b0, sysrst_pull}, 4'h0);
        step(FILT - 1);
        chk("R7 filtered end", {3'b0, sysrst_pull}, 4'h0);
        step(1);
        chk("R7 pull", {3'b0, sysrst_pull}, 4'h1);
        uv_ok = 4'hF;
        step(1);
        chk("R7 release", {3'b0, sysrst_pull}, 4'h0);
        step(1);
        chk("R10 no skip", gate_on, 4'h0);
        for (int t = 0; t < QUAL - 1; t++) tick1();
        chk("R10 wait", gate_on, 4'h0);
        tick1();
        chk("R10 restart", gate_on, 4'h1);

        // R7 short glitch never pulls
        uv_ok = 4'b0111;
        for (int c = 0; c < FILT; c++) begin
            step(1);
            chk("R7 glitch", {3'b0, sysrst_pull}, 4'h0);
        end
        uv_ok = 4'hF;
        step(1);
        chk("R7 glitch end", {3'b0, sysrst_pull}, 4'h0);

        // R8/R9: external low in run, release skips the wait
        bring_up(3);
        ext_line = 1'b0;
        step(1);
        chk("R8 gates", gate_on, 4'h0);
        chk("R8 good", {3'b0, pwr_good}, 4'h0);
        for (int t = 0; t < QUAL + 1; t++) tick1();
        chk("R8 held", gate_on, 4'h0);
        ext_line = 1'b1;
        step(1);
        chk("R9 skip", gate_on, 4'h1);
        ext_line = 1'b0;
        step(1);
        en_n = 1'b1;
        ext_line = 1'b1;
        step(3);
        chk("R9 no skip disabled", gate_on, 4'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule